// File: doc/BRIEF.md
# Bypass-Gated Array Multiplier

This block multiplies two unsigned M-bit operands and delivers the 2M-bit product from a register. Inside, the product is built by M carry-save adder stages, one for each bit of a controlling operand. Each stage adds a shifted copy of the other operand into a running sum word and carry word. A stage whose controlling bit is zero has nothing to add. Its adder inputs are held at zero so those adders do not toggle, and a multiplexer passes the sum and carry words from the stage above straight through. A ripple carry-propagate adder then merges the final sum and carry words.

A parameter chooses which operand controls the stages. In row mode, multiplier bit j enables stage j. In column mode, multiplicand bit i enables stage i. Both modes give the same product. The only difference is which operand's zero bits save switching.

Operands enter on a valid/ready handshake, and the product leaves on one. The output register accepts a new operand pair when it is empty or when its current product is being taken in the same cycle. A product that is not taken stays put. While it waits, the input is back-pressured.

Top module: `bypass_array_mult`

## Requirements
- R1: When a transfer occurs (in_valid and in_ready both high at a rising clock edge), the product out_product equals op_a times op_b as unsigned numbers in 2M bits. It appears with out_valid high after that same edge.
- R2: In row mode (MODE = BYP_ROW), stage j is controlled by op_b bit j. When that bit is 0, the stage's outgoing sum and carry words equal its incoming ones, and the product stays correct.
- R3: In column mode (MODE = BYP_COL), stage i is controlled by op_a bit i. The product is identical to the row-mode product for every operand pair.
- R4: in_ready is high exactly when the output register is empty or out_ready is high. A transfer loads the new product even in the cycle the old one is consumed.
- R5: While out_valid is high and out_ready is low, out_valid stays high, out_product holds its value, and in_ready is low.
- R6: After reset, out_valid is 0 and out_product is 0.
- R7: When a held product is consumed (out_valid and out_ready high) and no transfer occurs, out_valid is 0 after that edge.
- R8: Corner operands give exact results. A zero controlling operand bypasses every stage and gives 0. All-ones operands bypass no stage and give the maximum product. A controlling operand with a single set bit enables exactly one stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair is present |
| in_ready | output | 1 | Block can take an operand pair |
| op_a | input | M | Multiplicand, unsigned |
| op_b | input | M | Multiplier, unsigned |
| out_valid | output | 1 | out_product holds an untaken result |
| out_ready | input | 1 | Consumer takes the product |
| out_product | output | 2M | Registered unsigned product |

## Verification
Two symptoms point to a wrong internal state. A stage that passes the wrong word, drops a pending carry, or is enabled by the wrong bit shows up as a wrong product in the cycle right after the transfer. It appears only for operand pairs whose zero pattern steers around that stage, which is why every operand pair of a 4-bit build is swept in both modes. A wrong valid state shows up within one edge as a lost product, a duplicated product, or a product that changes while it is still being held under back-pressure. Those sequences are driven directly.

// File: rtl/bypass_mult_pkg.sv
package bypass_mult_pkg;

  // Which operand's bits enable the adder stages.
  typedef enum logic {
    BYP_ROW = 1'b0,
    BYP_COL = 1'b1
  } byp_mode_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/bypass_csa_row.sv
module bypass_csa_row
  import bypass_mult_pkg::*;
#(
  parameter int M   = 8,
  parameter int ROW = 0,
  localparam int W  = 2 * M
) (
  input  logic         en,
  input  logic [M-1:0] shift_op,
  input  logic [W-1:0] sum_in,
  input  logic [W-1:0] carry_in,
  output logic [W-1:0] sum_out,
  output logic [W-1:0] carry_out
);

  logic [W-1:0] pp_word;
  logic [W-1:0] g_sum, g_carry, g_pp;
  logic [W-1:0] fa_sum;
  logic [W-1:0] fa_carry;

  assign pp_word = W'(shift_op) << ROW;

  // Input gating: a disabled stage presents all-zero operands to its adders.
  assign g_sum   = sum_in   & {W{en}};
  assign g_carry = carry_in & {W{en}};
  assign g_pp    = pp_word  & {W{en}};

  assign fa_carry[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_fa
    assign fa_sum[k] = g_sum[k] ^ g_carry[k] ^ g_pp[k];
    if (k < W - 1) begin : g_cy
      assign fa_carry[k+1] = maj3(g_sum[k], g_carry[k], g_pp[k]);
    end
  end

  // Bypass multiplexers: a disabled stage forwards the words from above.
  assign sum_out   = en ? fa_sum   : sum_in;
  assign carry_out = en ? fa_carry : carry_in;

endmodule

// File: rtl/ripple_cpa.sv
module ripple_cpa
  import bypass_mult_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] s
);

  logic [W-1:0] c;

  assign c[0] = 1'b0;

  for (genvar k = 0; k < W; k++) begin : g_bit
    assign s[k] = x[k] ^ y[k] ^ c[k];
    if (k < W - 1) begin : g_cy
      assign c[k+1] = maj3(x[k], y[k], c[k]);
    end
  end

endmodule

// File: rtl/bypass_array_mult.sv
module bypass_array_mult
  import bypass_mult_pkg::*;
#(
  parameter int        M    = 8,
  parameter byp_mode_e MODE = BYP_ROW,
  localparam int       W    = 2 * M
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] op_a,
  input  logic [M-1:0] op_b,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_product
);

  logic [M-1:0]       row_en;
  logic [M-1:0]       shift_op;
  logic [M:0][W-1:0]  sum_chain;
  logic [M:0][W-1:0]  carry_chain;
  logic [W-1:0]       product_d;
  logic               load;

  // Parameter picks which operand enables the stages.
  if (MODE == BYP_ROW) begin : g_row_mode
    assign row_en   = op_b;
    assign shift_op = op_a;
  end else begin : g_col_mode
    assign row_en   = op_a;
    assign shift_op = op_b;
  end

  assign sum_chain[0]   = '0;
  assign carry_chain[0] = '0;

  for (genvar j = 0; j < M; j++) begin : g_stage
    bypass_csa_row #(
      .M   (M),
      .ROW (j)
    ) u_row (
      .en        (row_en[j]),
      .shift_op  (shift_op),
      .sum_in    (sum_chain[j]),
      .carry_in  (carry_chain[j]),
      .sum_out   (sum_chain[j+1]),
      .carry_out (carry_chain[j+1])
    );
  end

  ripple_cpa #(
    .W (W)
  ) u_cpa (
    .x (sum_chain[M]),
    .y (carry_chain[M]),
    .s (product_d)
  );

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_product <= '0;
    end else if (load) begin
      out_valid   <= 1'b1;
      out_product <= product_d;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

endmodule

// File: rtl/bypass_array_mult_chk.sv
module bypass_array_mult_chk #(
  parameter int  M = 8,
  localparam int W = 2 * M
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [M-1:0]      op_a,
  input logic [M-1:0]      op_b,
  input logic              out_valid,
  input logic              out_ready,
  input logic [W-1:0]      out_product,
  input logic [M-1:0]      row_en,
  input logic [M:0][W-1:0] sum_chain,
  input logic [M:0][W-1:0] carry_chain
);

  p_product_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=>
      out_valid && (out_product == W'($past(op_a)) * W'($past(op_b))));

  for (genvar j = 0; j < M; j++) begin : g_stage_chk
    p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !row_en[j] |->
        (sum_chain[j+1] == sum_chain[j]) && (carry_chain[j+1] == carry_chain[j]));
  end

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_product));

  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

endmodule

bind bypass_array_mult bypass_array_mult_chk #(.M(M)) u_chk (.*);

// File: tb/bypass_array_mult_test.sv
`timescale 1ns/1ps
module bypass_array_mult_test;
  import bypass_mult_pkg::*;

  localparam int M = 4;
  localparam int W = 2 * M;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         out_ready = 1'b0;
  logic [M-1:0] op_a = '0;
  logic [M-1:0] op_b = '0;
  logic         in_ready, in_ready_c;
  logic         out_valid, out_valid_c;
  logic [W-1:0] prod, prod_c;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bypass_array_mult #(.M(M), .MODE(BYP_ROW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_product(prod)
  );

  bypass_array_mult #(.M(M), .MODE(BYP_COL)) uut_col (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_c),
    .op_a(op_a), .op_b(op_b), .out_valid(out_valid_c), .out_ready(out_ready),
    .out_product(prod_c)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One isolated transfer, result checked on both variants.
  task automatic one_op(input string req, input int a, input int b);
    @(negedge clk);
    op_a = M'(a); op_b = M'(b); in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " row valid"}, 32'(out_valid), 32'd1);
    check({req, " row"}, 32'(prod), 32'(a * b));
    check({req, " col"}, 32'(prod_c), 32'(a * b));
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pa, pb;
    bit have;
    // R6: reset state
    repeat (2) @(negedge clk);
    check("R6 out_valid", 32'(out_valid), 32'd0);
    check("R6 out_product", 32'(prod), 32'd0);
    check("R6 col out_valid", 32'(out_valid_c), 32'd0);
    check("R4 ready when empty", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    // R1 / R3: exhaustive back-to-back sweep, consumer always ready
    out_ready = 1'b1;
    have = 1'b0; pa = 0; pb = 0;
    for (int a = 0; a < (1 << M); a++) begin
      for (int b = 0; b < (1 << M); b++) begin
        @(negedge clk);
        if (have) begin
          check("R1 row product", 32'(prod), 32'(pa * pb));
          check("R3 col product", 32'(prod_c), 32'(pa * pb));
        end
        op_a = M'(a); op_b = M'(b); in_valid = 1'b1;
        pa = a; pb = b; have = 1'b1;
      end
    end
    @(negedge clk);
    check("R1 row product", 32'(prod), 32'(pa * pb));
    check("R3 col product", 32'(prod_c), 32'(pa * pb));
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 drained", 32'(out_valid), 32'd0);
    check("R7 col drained", 32'(out_valid_c), 32'd0);

    // R2: multiplier with zero bits bypasses stages in row mode
    one_op("R2 b=0101", 11, 5);
    one_op("R2 b=1000", 7, 8);
    // R8: corners
    one_op("R8 zero ctrl b", 15, 0);
    one_op("R8 zero ctrl a", 0, 15);
    one_op("R8 all ones", 15, 15);
    one_op("R8 single bit", 13, 4);

    // R4 / R5: back-pressure
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; op_a = 4'd9; op_b = 4'd7;
    @(negedge clk);
    check("R4 ready low when full", 32'(in_ready), 32'd0);
    check("R5 product", 32'(prod), 32'd63);
    op_a = 4'd5; op_b = 4'd3;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R5 held valid", 32'(out_valid), 32'd1);
      check("R5 held product", 32'(prod), 32'd63);
      check("R5 col held product", 32'(prod_c), 32'd63);
    end
    out_ready = 1'b1;
    #1;
    check("R4 ready follows out_ready", 32'(in_ready), 32'd1);
    @(negedge clk);
    check("R4 replace on consume", 32'(prod), 32'd15);
    check("R4 valid on replace", 32'(out_valid), 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R7 valid drops", 32'(out_valid), 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule